// File: doc/BRIEF.md
# Power-Fail Gated Byte Bus Front End

This block sits between an asynchronous bytewide memory port and the storage behind it. It samples the three active-low strobes (chip enable, output enable, write enable), an address and a data byte, and turns them into a read indication, a data-bus drive enable and a one-cycle write commit strobe that carries the captured address and data to the storage array. The strobes are taken as already synchronised to the block clock.

Two supply-status inputs from external comparators gate every access. One flag reports that the supply is below the power-fail level. The other reports that it is below the battery switchover level. While either flag is raised, the port is deselected whatever the strobes say. The data bus stays undriven and any write in flight is thrown away. Below the switchover level the block also raises a retention-mode flag. After the supply flags clear, the lockout holds for a fixed, parameterised number of clocks before access is allowed again.

A write is committed only when its write condition ends, that is when chip enable or write enable returns high. A write is discarded if the supply was flagged at any sampled clock during its span.

Top module: `pfbus_gate`

## Requirements
- R1: While `bus_ce_n` is 1, `dq_oe` and `rd_act` are 0 and no write is committed, for any value of the other strobes.
- R2: With `bus_ce_n`=0 and `bus_we_n`=0, the cycle is a write whatever `bus_oe_n` is: `dq_oe` and `rd_act` stay 0.
- R3: With no lockout, `bus_ce_n`=0, `bus_oe_n`=0 and `bus_we_n`=1, `dq_oe` and `rd_act` are 1 in the same cycle (combinational from the strobes).
- R4: With `bus_ce_n`=0 and both `bus_oe_n` and `bus_we_n` at 1, `dq_oe`, `rd_act` and `wr_stb` are all 0.
- R5: While `sup_fail`=1, `dq_oe` and `rd_act` are 0 whatever the strobes are.
- R6: `retain` equals `sup_swo`. Raising `sup_swo` also locks the port exactly as `sup_fail` does.
- R7: When a write condition (`bus_ce_n`=0 and `bus_we_n`=0) ends at a clock edge, `wr_stb` is 1 for exactly one cycle after that edge. `wr_addr`/`wr_data` then hold the address and data sampled at the last edge while the condition held. A write may be ended by either strobe.
- R8: A write is not committed if lockout was in force at any edge during its condition, or at the edge where it ends.
- R9: After the last edge that samples a raised supply flag, the lockout holds for `RECOV_CYCLES` further edges. Reads are enabled again in the cycle after the `RECOV_CYCLES`-th edge.
- R10: During and right after reset, `wr_stb`, `dq_oe`, `rd_act` and `retain` are 0 and the port is not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | ADDR_W (11) | Byte address |
| bus_din | input | DATA_W (8) | Write data from the bus |
| sup_fail | input | 1 | Supply below the power-fail level |
| sup_swo | input | 1 | Supply below the switchover level |
| wr_stb | output | 1 | One-cycle write commit to storage |
| wr_addr | output | ADDR_W (11) | Address of the committed write |
| wr_data | output | DATA_W (8) | Data of the committed write |
| rd_act | output | 1 | Read access in progress |
| dq_oe | output | 1 | Data bus drive enable |
| retain | output | 1 | Data-retention mode flag |

## Verification
The hardest case to reach is a write whose only defect is a supply glitch in its middle. The recovery counter would block the commit by itself unless the write outlasts it. So the stimulus raises `sup_fail` for one edge while the write strobes are held, clears it, and then keeps the write condition asserted for more than `RECOV_CYCLES` edges before releasing it. At that point only the remembered glitch can suppress the commit. A second case lines the supply flag up with the very edge that ends the write. Recovery timing is probed one edge before and one edge after the lockout expires.

// File: rtl/pfbus_pkg.sv
package pfbus_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_DESEL = 2'd3
  } acc_e;

  // Priority: lockout, then chip enable, then write enable, then output enable.
  function automatic acc_e decode_access(input logic ce_n, input logic oe_n,
                                         input logic we_n, input logic locked);
    if (locked || ce_n) return ACC_DESEL;
    if (!we_n)          return ACC_WRITE;
    if (!oe_n)          return ACC_READ;
    return ACC_IDLE;
  endfunction

  // Raw write condition, independent of supply state.
  function automatic logic write_cond(input logic ce_n, input logic we_n);
    return !ce_n && !we_n;
  endfunction

  // Lockout countdown step.
  function automatic int unsigned recov_next(input logic fail, input int unsigned cnt,
                                             input int unsigned reload);
    if (fail)      return reload;
    if (cnt != 0)  return cnt - 1;
    return 0;
  endfunction

endpackage

// File: rtl/pfbus_lockout.sv
module pfbus_lockout #(
  parameter int unsigned RECOV_CYCLES = 16,
  localparam int unsigned CNT_W = $clog2(RECOV_CYCLES + 1) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_fail,
  input  logic sup_swo,
  output logic fail_now,
  output logic locked,
  output logic retain
);
  import pfbus_pkg::*;

  logic [CNT_W-1:0] recov_cnt;
  logic             recov_busy;

  assign fail_now   = sup_fail | sup_swo;
  assign retain     = sup_swo;
  assign recov_busy = (recov_cnt != '0);
  assign locked     = fail_now | recov_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recov_cnt <= '0;
    else        recov_cnt <= CNT_W'(recov_next(fail_now, int'(recov_cnt), RECOV_CYCLES));
  end

  assert_retain_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retain |-> locked);

  generate
    if (RECOV_CYCLES > 0) begin : g_hold_chk
      assert_hold_after_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fail_now) && !fail_now) |-> locked);
    end
  endgenerate

  assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    recov_cnt <= CNT_W'(RECOV_CYCLES));

endmodule

// File: rtl/pfbus_decode.sv
module pfbus_decode (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              locked,
  output pfbus_pkg::acc_e   mode,
  output logic              wcond,
  output logic              dq_oe,
  output logic              rd_act
);
  import pfbus_pkg::*;

  assign mode   = decode_access(ce_n, oe_n, we_n, locked);
  assign wcond  = write_cond(ce_n, we_n);
  assign rd_act = (mode == ACC_READ);
  assign dq_oe  = rd_act;

  assert_ce_high_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dq_oe && !rd_act));
  assert_write_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |-> !dq_oe);
  assert_idle_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && we_n) |-> !dq_oe);
  assert_locked_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !dq_oe);

endmodule

// File: rtl/pfbus_wrcap.sv
module pfbus_wrcap #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wcond,
  input  logic              locked,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_end
);
  logic wcond_q;
  logic spoil_q;
  logic wr_start;

  assign wr_start = wcond && !wcond_q;
  assign wr_end   = wcond_q && !wcond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcond_q <= 1'b0;
      spoil_q <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wcond_q <= wcond;
      wr_stb  <= wr_end && !spoil_q && !locked;
      if (wr_start)   spoil_q <= locked;
      else if (wcond) spoil_q <= spoil_q | locked;
      if (wcond) begin
        wr_addr <= addr;
        wr_data <= din;
      end
    end
  end

  assert_no_commit_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !$past(locked));
  assert_commit_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !$past(wcond));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

endmodule

// File: rtl/pfbus_gate.sv
module pfbus_gate #(
  parameter int unsigned ADDR_W       = 11,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned RECOV_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              sup_fail,
  input  logic              sup_swo,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_act,
  output logic              dq_oe,
  output logic              retain
);
  import pfbus_pkg::*;

  logic fail_now;
  logic locked;
  logic wcond;
  logic wr_end;
  acc_e mode;

  pfbus_lockout #(.RECOV_CYCLES(RECOV_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .sup_fail(sup_fail), .sup_swo(sup_swo),
    .fail_now(fail_now), .locked(locked), .retain(retain)
  );

  pfbus_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
    .locked(locked), .mode(mode), .wcond(wcond), .dq_oe(dq_oe), .rd_act(rd_act)
  );

  pfbus_wrcap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wcond(wcond), .locked(locked),
    .addr(bus_addr), .din(bus_din), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_end(wr_end)
  );

  assert_retain_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retain |-> (!dq_oe && !rd_act));
  assert_fail_blocks_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_now |-> (mode == ACC_DESEL));
  assert_end_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && fail_now) |=> !wr_stb);

endmodule

// File: tb/tb_pfbus_gate.sv
module tb_pfbus_gate;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int NREC = 16;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } wr_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic sfail = 1'b0, sswo = 1'b0;
  logic wr_stb, rd_act, dq_oe, retain;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int fails = 0;
  wr_item_t expq[$];

  always #5 clk = ~clk;

  pfbus_gate #(.ADDR_W(AW), .DATA_W(DW), .RECOV_CYCLES(NREC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_din(din), .sup_fail(sfail), .sup_swo(sswo),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_act(rd_act), .dq_oe(dq_oe), .retain(retain)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobes(input logic c, input logic o, input logic w);
    ce_n = c; oe_n = o; we_n = w;
  endtask

  task automatic expect_rd(input logic e, input string req);
    #1;
    chk(dq_oe == e, req, dq_oe, e);
    chk(rd_act == e, req, rd_act, e);
  endtask

  // Monitor: compare each commit strobe with the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R7/R8 unexpected commit", {wr_addr, wr_data}, 0);
      end else begin
        wr_item_t e;
        e = expq.pop_front();
        chk({wr_addr, wr_data} == e, "R7 commit content", {wr_addr, wr_data}, e);
      end
    end
  end

  // Driver: a write held for n edges, ending by we_n (by_ce=0) or ce_n.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int n, input logic o, input logic by_ce, input logic commit);
    wr_item_t it;
    @(negedge clk);
    addr = a; din = d; strobes(1'b0, o, 1'b0);
    #1;
    chk(dq_oe == 1'b0, "R2 no drive during write", dq_oe, 0);
    repeat (n) @(negedge clk);
    it.a = a; it.d = d;
    if (commit) expq.push_back(it);
    if (by_ce) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk);
    strobes(1'b1, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(wr_stb == 0 && dq_oe == 0 && rd_act == 0 && retain == 0, "R10 reset outputs",
        {wr_stb, dq_oe, rd_act, retain}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    strobes(1'b0, 1'b0, 1'b1);
    expect_rd(1'b1, "R10 not locked after reset");
    strobes(1'b1, 1'b1, 1'b1);

    // R1: chip enable high masks everything
    @(negedge clk); strobes(1'b1, 1'b0, 1'b1); expect_rd(1'b0, "R1 ce high read");
    @(negedge clk); strobes(1'b1, 1'b0, 1'b0); expect_rd(1'b0, "R1 ce high write");
    repeat (3) @(negedge clk);
    strobes(1'b1, 1'b1, 1'b1);
    repeat (2) @(negedge clk);

    // R3 and R4
    strobes(1'b0, 1'b0, 1'b1); expect_rd(1'b1, "R3 read decode");
    @(negedge clk); strobes(1'b0, 1'b1, 1'b1); expect_rd(1'b0, "R4 idle decode");
    @(negedge clk); strobes(1'b1, 1'b1, 1'b1);

    // R2/R7: writes with both output-enable levels and both ending strobes
    do_write(11'h123, 8'hA5, 1, 1'b1, 1'b0, 1'b1);
    do_write(11'h7FF, 8'h3C, 3, 1'b0, 1'b0, 1'b1);
    do_write(11'h001, 8'hF0, 2, 1'b1, 1'b1, 1'b1);
    do_write(11'h400, 8'h81, 2, 1'b0, 1'b1, 1'b1);

    // R7: data changes mid-cycle, last sampled value is committed
    begin
      wr_item_t it;
      @(negedge clk);
      addr = 11'h055; din = 8'h11; strobes(1'b0, 1'b1, 1'b0);
      @(negedge clk); addr = 11'h2AA; din = 8'h22;
      @(negedge clk);
      it.a = 11'h2AA; it.d = 8'h22; expq.push_back(it);
      we_n = 1'b1; addr = 11'h000; din = 8'h00;
      @(negedge clk); strobes(1'b1, 1'b1, 1'b1);
      repeat (2) @(negedge clk);
    end
    chk(expq.size() == 0, "R7 all commits seen", expq.size(), 0);

    // R5: supply fail masks reads
    sfail = 1'b1; strobes(1'b0, 1'b0, 1'b1); expect_rd(1'b0, "R5 read blocked");
    // R9: recovery timing
    @(negedge clk); sfail = 1'b0;
    repeat (NREC - 1) @(negedge clk);
    expect_rd(1'b0, "R9 still locked one edge before");
    @(negedge clk);
    expect_rd(1'b1, "R9 access resumes");
    strobes(1'b1, 1'b1, 1'b1);

    // R8: glitch in the middle of a long write
    @(negedge clk);
    addr = 11'h0F0; din = 8'h5A; strobes(1'b0, 1'b1, 1'b0);
    @(negedge clk); sfail = 1'b1;
    @(negedge clk); sfail = 1'b0;
    repeat (NREC + 3) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    strobes(1'b1, 1'b1, 1'b1);
    chk(wr_stb == 1'b0, "R8 mid-write glitch discarded", wr_stb, 0);

    // R8: fail flagged at the ending edge
    @(negedge clk);
    addr = 11'h0F1; din = 8'h6B; strobes(1'b0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    we_n = 1'b1; sfail = 1'b1;
    @(negedge clk); sfail = 1'b0; strobes(1'b1, 1'b1, 1'b1);
    repeat (NREC + 2) @(negedge clk);

    // R8 control: normal write succeeds after recovery
    do_write(11'h0F2, 8'h7C, 2, 1'b1, 1'b0, 1'b1);

    // R6: retention mode
    sswo = 1'b1; strobes(1'b0, 1'b0, 1'b1);
    #1; chk(retain == 1'b1, "R6 retain raised", retain, 1);
    expect_rd(1'b0, "R6 retention locks port");
    @(negedge clk); sswo = 1'b0;
    #1; chk(retain == 1'b0, "R6 retain cleared", retain, 0);
    expect_rd(1'b0, "R6 recovery after switchover");
    strobes(1'b1, 1'b1, 1'b1);
    repeat (NREC + 2) @(negedge clk);
    strobes(1'b0, 1'b0, 1'b1); expect_rd(1'b1, "R6 access back after recovery");
    strobes(1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);

    chk(expq.size() == 0, "R7 scoreboard empty", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule